// File: doc/BRIEF.md
# Two-Entry Overrun-Protected Receive Buffer

This block is the buffered store behind the last receive message slot of a CAN controller. The acceptance logic hands it complete frames: an identifier of up to 29 bits, a flag for the extended identifier format, a data length and eight data bytes. It keeps up to two of these frames for the host. The host always sees the oldest stored frame on a read port and releases it with a one-cycle pop strobe. The remaining frame then moves up to the head.

When both entries are occupied and a further frame arrives, the newer stored frame is replaced and the older one is kept untouched. The older frame remains the next one the host reads. Each replacement sets a sticky overrun flag, which the host clears by writing one. The block also drives empty and full status and a new-data interrupt that stays high while anything is stored.

Top module: `rx_pair_buffer`

## Requirements
- R1: A clock edge with rst_n low empties the buffer and clears the overrun flag, so afterwards empty=1, full=0, overrun=0 and irq=0.
- R2: A frame written while the buffer is empty appears on the read port (rd_id, rd_ext, rd_len, rd_data) in the cycle after the write, and empty falls in that same cycle.
- R3: Frames are read in arrival order: with two frames stored, the read port shows the first, and after a pop it shows the second.
- R4: full is 1 exactly when two frames are stored, and empty is 1 exactly when none are stored.
- R5: A write while full with no pop replaces the second stored frame. The head frame on the read port stays unchanged and the buffer stays full.
- R6: The overrun flag goes to 1 in the cycle after a replacement and stays 1 until it is cleared.
- R7: A one on ovr_clear clears the overrun flag at the next edge. If a replacement happens in the same cycle, the flag is set instead.
- R8: A write and a pop in the same cycle while full perform the pop first. The old second frame becomes the head, the new frame becomes the second entry, the buffer stays full and no overrun is flagged.
- R9: A write and a pop in the same cycle with one frame stored leave one frame stored, and that frame is the new one.
- R10: A pop while the buffer is empty is ignored and leaves the buffer and its flags unchanged.
- R11: irq equals the inverse of empty in every cycle.
- R12: A write and a pop in the same cycle while empty store the written frame. The pop has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe: an accepted frame is presented |
| wr_id | input | 29 | Identifier of the incoming frame |
| wr_ext | input | 1 | 1 = extended identifier format |
| wr_len | input | 4 | Data length of the incoming frame (0 to 8) |
| wr_data | input | 64 | Data bytes of the incoming frame, byte 0 in bits 7:0 |
| pop | input | 1 | Host releases the head frame |
| ovr_clear | input | 1 | Host write-one-to-clear of the overrun flag |
| rd_id | output | 29 | Identifier of the head frame |
| rd_ext | output | 1 | Format flag of the head frame |
| rd_len | output | 4 | Data length of the head frame |
| rd_data | output | 64 | Data bytes of the head frame |
| empty | output | 1 | No frame stored |
| full | output | 1 | Two frames stored |
| overrun | output | 1 | Sticky: a stored frame has been replaced |
| irq | output | 1 | New-data interrupt, high while not empty |

## Verification
The hardest cases to reach from the ports are those where several events land on one edge. One is a pop together with a write while full, which must shift the queue rather than flag an overrun. Another is a replacement in the same cycle as an overrun clear. The stimulus first fills the buffer with two writes, so the full state is known, and then drives the coincident strobes in a single cycle. Repeated overflow writes confirm that only the second entry ever changes, and the scoreboard checks the head frame after every cycle.

// File: rtl/rxbuf_pkg.sv
// Shared widths and types for the two-entry receive buffer.
// Assumes a classic CAN payload of at most eight bytes.
package rxbuf_pkg;
    localparam int ID_W       = 29;
    localparam int DATA_BYTES = 8;
    localparam int DATA_W     = 8 * DATA_BYTES;
    localparam int LEN_W      = $clog2(DATA_BYTES + 1);
    localparam int DEPTH      = 2;
    localparam int CNT_W      = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ext;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } rx_frame_t;

    // Source selected for the head entry on the next edge
    typedef enum logic [1:0] {
        HEAD_HOLD    = 2'd0,
        HEAD_LOAD_IN = 2'd1,
        HEAD_SHIFT   = 2'd2
    } head_src_e;
endpackage

// File: rtl/rxb_ctrl.sv
// Occupancy controller: tracks how many frames are held and decides, per
// cycle, how the head and tail entries are loaded. A pop is applied before
// a write in the same cycle; a pop on an empty buffer is discarded.
// Assumes wr_valid and pop are single-cycle strobes.
module rxb_ctrl
    import rxbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             pop,
    output head_src_e        head_src,
    output logic             tail_load,
    output logic             replace,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic             pop_ok;
    logic [CNT_W-1:0] count_nxt;

    // Decode the strobes into load controls and the next occupancy
    always_comb begin
        pop_ok    = pop && (count != CNT_ZERO);
        head_src  = HEAD_HOLD;
        tail_load = 1'b0;
        replace   = 1'b0;
        count_nxt = count;
        unique case ({wr_valid, pop_ok})
            2'b10: begin
                if (count == CNT_ZERO) begin
                    head_src  = HEAD_LOAD_IN;
                    count_nxt = CNT_ONE;
                end else if (count == CNT_ONE) begin
                    tail_load = 1'b1;
                    count_nxt = CNT_FULL;
                end else begin
                    tail_load = 1'b1;
                    replace   = 1'b1;
                end
            end
            2'b01: begin
                head_src  = HEAD_SHIFT;
                count_nxt = count - CNT_ONE;
            end
            2'b11: begin
                if (count == CNT_ONE) begin
                    head_src = HEAD_LOAD_IN;
                end else begin
                    head_src  = HEAD_SHIFT;
                    tail_load = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Occupancy register
    always_ff @(posedge clk) begin
        if (!rst_n) count <= CNT_ZERO;
        else        count <= count_nxt;
    end
endmodule

// File: rtl/rxb_slots.sv
// Frame storage: a head entry and a tail entry. The head can hold, take
// the incoming frame or take the tail; the tail only takes the incoming
// frame. Assumes the controller never asks for an impossible move.
module rxb_slots
    import rxbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  head_src_e head_src,
    input  logic      tail_load,
    input  rx_frame_t in_frame,
    output rx_frame_t head_frame
);
    rx_frame_t slot_q [DEPTH];

    // Head entry update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q[0] <= '0;
        end else begin
            unique case (head_src)
                HEAD_LOAD_IN: slot_q[0] <= in_frame;
                HEAD_SHIFT:   slot_q[0] <= slot_q[1];
                default:      slot_q[0] <= slot_q[0];
            endcase
        end
    end

    // Tail entries (one for the default depth) take the incoming frame
    for (genvar g = 1; g < DEPTH; g++) begin : g_tail
        always_ff @(posedge clk) begin
            if (!rst_n)         slot_q[g] <= '0;
            else if (tail_load) slot_q[g] <= in_frame;
        end
    end

    assign head_frame = slot_q[0];
endmodule

// File: rtl/rxb_status.sv
// Status logic: empty/full/interrupt from occupancy and the sticky overrun
// flag. A replacement wins over a clear in the same cycle.
module rxb_status
    import rxbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             replace,
    input  logic             ovr_clear,
    output logic             empty,
    output logic             full,
    output logic             irq,
    output logic             overrun
);
    // Occupancy-derived status
    always_comb begin
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
        irq   = !empty;
    end

    // Sticky overrun flag, write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)         overrun <= 1'b0;
        else if (replace)   overrun <= 1'b1;
        else if (ovr_clear) overrun <= 1'b0;
    end
endmodule

// File: rtl/rx_pair_buffer.sv
// Two-entry receive buffer that keeps the oldest frame on overflow.
// Incoming frames are stored in order; on overflow the newer stored
// frame is replaced. The host reads the head and pops it.
// Assumes one write and one pop strobe at most per cycle.
module rx_pair_buffer
    import rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_id,
    input  logic              wr_ext,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    input  logic              ovr_clear,
    output logic [ID_W-1:0]   rd_id,
    output logic              rd_ext,
    output logic [LEN_W-1:0]  rd_len,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              overrun,
    output logic              irq
);
    head_src_e        head_src;
    logic             tail_load;
    logic             replace;
    logic [CNT_W-1:0] count;
    rx_frame_t        in_frame;
    rx_frame_t        head_frame;

    // Pack the incoming fields into one frame
    always_comb begin
        in_frame.id   = wr_id;
        in_frame.ext  = wr_ext;
        in_frame.len  = wr_len;
        in_frame.data = wr_data;
    end

    rxb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .pop       (pop),
        .head_src  (head_src),
        .tail_load (tail_load),
        .replace   (replace),
        .count     (count)
    );

    rxb_slots u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_src   (head_src),
        .tail_load  (tail_load),
        .in_frame   (in_frame),
        .head_frame (head_frame)
    );

    rxb_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (count),
        .replace   (replace),
        .ovr_clear (ovr_clear),
        .empty     (empty),
        .full      (full),
        .irq       (irq),
        .overrun   (overrun)
    );

    // Unpack the head frame onto the read port
    always_comb begin
        rd_id   = head_frame.id;
        rd_ext  = head_frame.ext;
        rd_len  = head_frame.len;
        rd_data = head_frame.data;
    end
endmodule

// File: rtl/rx_pair_buffer_checker.sv
// Port-level properties of the receive buffer, bound to every instance.
module rx_pair_buffer_checker
    import rxbuf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ID_W-1:0]   wr_id,
    input logic [DATA_W-1:0] wr_data,
    input logic              pop,
    input logic              ovr_clear,
    input logic [ID_W-1:0]   rd_id,
    input logic [DATA_W-1:0] rd_data,
    input logic              empty,
    input logic              full,
    input logic              overrun,
    input logic              irq
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !overrun));

    assert_first_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && empty) |=> (!empty && rd_id == $past(wr_id) && rd_data == $past(wr_data)));

    assert_not_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_head_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full && !pop) |=> (full && $stable(rd_id) && $stable(rd_data)));

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full && !pop) |=> overrun);

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clear) |=> overrun);

    assert_overrun_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clear && !(wr_valid && full && !pop)) |=> !overrun);

    assert_push_pop_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && pop && full && !overrun) |=> (full && !overrun));

    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !wr_valid) |=> (empty && $stable(overrun)));

    assert_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !empty);
endmodule

bind rx_pair_buffer rx_pair_buffer_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_id     (wr_id),
    .wr_data   (wr_data),
    .pop       (pop),
    .ovr_clear (ovr_clear),
    .rd_id     (rd_id),
    .rd_data   (rd_data),
    .empty     (empty),
    .full      (full),
    .overrun   (overrun),
    .irq       (irq)
);

// File: tb/rx_pair_buffer_test.sv
// Scoreboard bench: the driver task applies one cycle of stimulus and
// updates a reference queue; the monitor compares every cycle.
module rx_pair_buffer_test;
    import rxbuf_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b1;
    logic              wr_valid = 1'b0;
    logic [ID_W-1:0]   wr_id = '0;
    logic              wr_ext = 1'b0;
    logic [LEN_W-1:0]  wr_len = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              pop = 1'b0;
    logic              ovr_clear = 1'b0;
    logic [ID_W-1:0]   rd_id;
    logic              rd_ext;
    logic [LEN_W-1:0]  rd_len;
    logic [DATA_W-1:0] rd_data;
    logic              empty, full, overrun, irq;

    rx_frame_t exp_q[$];
    logic      exp_ovr = 1'b0;
    bit        mon_en = 1'b0;
    string     cur_tag = "R1";
    int        n_vec = 0;
    int        n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_pair_buffer uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_id(wr_id),
        .wr_ext(wr_ext), .wr_len(wr_len), .wr_data(wr_data), .pop(pop),
        .ovr_clear(ovr_clear), .rd_id(rd_id), .rd_ext(rd_ext), .rd_len(rd_len),
        .rd_data(rd_data), .empty(empty), .full(full), .overrun(overrun), .irq(irq)
    );

    function automatic rx_frame_t mk(int n);
        rx_frame_t f;
        f.id   = ID_W'(32'h0A5C_0000 + n * 32'h0001_3579);
        f.ext  = n[0];
        f.len  = LEN_W'(n % (DATA_BYTES + 1));
        f.data = {DATA_BYTES{8'(n * 17 + 3)}} ^ DATA_W'(n);
        return f;
    endfunction

    task automatic check(bit ok, string field, logic [127:0] act, logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_tag, field, act, exp);
        end
    endtask

    // Monitor: compare the ports against the reference every cycle
    always @(negedge clk) begin
        if (mon_en) begin
            check(empty == (exp_q.size() == 0), "R4 empty", 128'(empty), 128'(exp_q.size() == 0));
            check(full == (exp_q.size() == 2), "R4 full", 128'(full), 128'(exp_q.size() == 2));
            check(overrun == exp_ovr, "R6 overrun", 128'(overrun), 128'(exp_ovr));
            check(irq == (exp_q.size() != 0), "R11 irq", 128'(irq), 128'(exp_q.size() != 0));
            if (exp_q.size() != 0)
                check({rd_id, rd_ext, rd_len, rd_data} == exp_q[0], "R3 head frame",
                      128'({rd_id, rd_ext, rd_len, rd_data}), 128'(exp_q[0]));
        end
    end

    // Driver: one cycle of stimulus plus the reference update
    task automatic step(bit w, int n, bit p, bit c, string tag);
        rx_frame_t f;
        bit        popped;
        bit        repl;
        f = mk(n);
        wr_valid = w; pop = p; ovr_clear = c;
        {wr_id, wr_ext, wr_len, wr_data} = f;
        @(posedge clk);
        #1;
        cur_tag = tag;
        popped = p && exp_q.size() > 0;
        repl = 1'b0;
        if (popped) void'(exp_q.pop_front());
        if (w) begin
            if (exp_q.size() < 2) exp_q.push_back(f);
            else begin exp_q[1] = f; repl = 1'b1; end
        end
        if (repl) exp_ovr = 1'b1;
        else if (c) exp_ovr = 1'b0;
        @(negedge clk);
        wr_valid = 1'b0; pop = 1'b0; ovr_clear = 1'b0;
    endtask

    task automatic do_reset(string tag);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        cur_tag = tag;
        exp_q.delete();
        exp_ovr = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("R1");
        step(0, 0, 1, 0, "R10");          // pop on empty
        step(1, 1, 0, 0, "R2");           // first write
        step(1, 2, 0, 0, "R3");           // fill
        step(0, 0, 0, 0, "R4");
        step(1, 3, 0, 0, "R5");           // overflow replaces tail
        step(1, 4, 0, 0, "R5");
        step(0, 0, 0, 0, "R6");           // flag sticky
        step(0, 0, 0, 1, "R7");           // clear
        step(1, 5, 0, 1, "R7");           // set wins over clear
        step(0, 0, 0, 1, "R7");
        step(1, 6, 1, 0, "R8");           // push+pop while full
        step(0, 0, 1, 0, "R3");
        step(1, 7, 1, 0, "R9");           // push+pop with one stored
        step(0, 0, 1, 0, "R3");
        step(0, 0, 1, 0, "R10");
        step(1, 8, 1, 0, "R12");          // push+pop while empty
        step(1, 9, 0, 0, "R3");
        step(1, 10, 0, 0, "R5");
        do_reset("R1");                   // reset while full with overrun
        for (int i = 0; i < 200; i++)
            step(((i * 7) % 3) != 0, 20 + i, ((i * 5) % 4) == 1, (i % 9) == 4, "R11");
        step(0, 0, 1, 0, "R3");
        step(0, 0, 1, 0, "R3");
        step(0, 0, 1, 0, "R10");
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule